// File: doc/BRIEF.md
# Vectored Maskable Interrupt Controller

This block gathers ten interrupt request lines from the peripherals of a small microcontroller and gives the CPU one request line together with a 4-bit vector index. The sources are a bus reset, a 128 µs timer tick, a 1.024 ms timer tick, three endpoint-completion events, two capture events, a wake-up timer and one merged GPIO request. Each source has its own vector. Every source reports an event as a one-cycle pulse. An endpoint pulses once a bus transaction has finished, and a capture unit pulses each time it stores a new timer value. The controller records each pulse in a pending latch for that source.

Firmware supplies a per-source enable mask and sets a global enable with a strobe. When the global enable is set and at least one pending source is enabled, the controller selects the enabled pending source with the lowest index. It registers that index as the vector and raises the request. The request is held until the CPU acknowledges it. The acknowledge clears only the serviced source's pending latch and clears the global enable, so firmware must set the global enable again before the next request can be raised.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `irqReq` is 0, `irqVec` is 0, `pending` is all zeros and `gieOut` is 0.
- R2: A 1 on `srcPulse[i]` sets `pending[i]` at the next clock edge, and the bit stays set until source i is acknowledged.
- R3: When `gieOut` is 1 and `pending & enableMask` is non-zero, `irqReq` rises at the next clock edge.
- R4: The vector is the lowest set index of `pending & enableMask`, and bit i maps to vector i. The mapping is 0 bus reset, 1 the 128 µs tick, 2 the 1.024 ms tick, 3 to 5 the endpoints, 6 and 7 the captures, 8 the wake-up timer and 9 GPIO.
- R5: A pending source whose enable bit is 0 raises no request and stays pending. If its enable bit is later set, it is served.
- R6: While `irqReq` is 1, `irqVec` does not change, even if a higher-priority source becomes pending.
- R7: `ack` while `irqReq` is 1 clears only `pending[irqVec]`, and both `irqReq` and `gieOut` are 0 after that edge.
- R8: `gieSet` sets `gieOut` at the next edge. While `gieOut` is 0, no request is raised. When `ack` and `gieSet` arrive in the same cycle, the `ack` wins.
- R9: `ack` while `irqReq` is 0 has no effect on `pending` or `gieOut`.
- R10: A pulse from a source in the same cycle as the acknowledge of that source leaves its pending bit set.
- R11: A pulse that arrives during a request is held as pending and is served after the current request has been acknowledged and the global enable set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcPulse | input | 10 | One-cycle event pulses, one bit per source |
| enableMask | input | 10 | Per-source enable, where 1 means the source may request |
| gieSet | input | 1 | Strobe that sets the global enable |
| ack | input | 1 | CPU acknowledge of the current request |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqVec | output | 4 | Index of the source being requested |
| pending | output | 10 | Pending latches |
| gieOut | output | 1 | Current global enable |

## Verification
A source pulse shows up in `pending` one edge later. A request needs a second edge, because the winner is registered only after both the pending bit and the global enable are already set. As a result, a pulse and a `gieSet` given in the same cycle produce `irqReq` and `irqVec` two edges later. An acknowledge clears the pending bit, `irqReq` and `gieOut` at the very next edge. The bench drives and samples only on the falling clock edge, and it counts rising edges between stimulus and check to match these latencies exactly.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC = 10;
  localparam int VEC_W   = $clog2(NUM_SRC);

  // Strobes from control to datapath
  typedef struct packed {
    logic loadVec;  // capture the current winner into the vector register
    logic clrSel;   // clear the pending bit selected by the vector register
  } irqStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } irqState_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int VW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcPulse,
  input  logic [NSRC-1:0] enableMask,
  input  irqStrobe_t      strobes,
  output logic            anyCand,
  output logic [VW-1:0]   vecQ,
  output logic [NSRC-1:0] pendQ
);
  logic [NSRC-1:0] cand;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] clrMask;
  logic [VW-1:0]   winIdx;

  assign cand    = pendQ & enableMask;
  assign anyCand = |cand;

  // Fixed priority: a lower index beats every higher index
  for (genvar i = 0; i < NSRC; i++) begin : g_grant
    if (i == 0) begin : g_top
      assign grant[i] = cand[i];
    end else begin : g_rest
      assign grant[i] = cand[i] & ~(|cand[i-1:0]);
    end
  end

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) winIdx = winIdx | VW'(i);
    end
  end

  // One-hot clear for the serviced source
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      clrMask[i] = strobes.clrSel && (vecQ == VW'(i));
    end
  end

  // A new pulse wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      pendQ <= (pendQ & ~clrMask) | srcPulse;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecQ <= '0;
    end else if (strobes.loadVec) begin
      vecQ <= winIdx;
    end
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyCand,
  input  logic       gieSet,
  input  logic       ack,
  output irqStrobe_t strobes,
  output logic       reqQ,
  output logic       gieQ
);
  irqState_t stateQ, stateD;

  always_comb begin
    strobes.loadVec = (stateQ == ST_IDLE) && gieQ && anyCand;
    strobes.clrSel  = (stateQ == ST_REQ) && ack;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (strobes.loadVec) stateD = ST_REQ;
      ST_REQ:  if (ack)             stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  // Acknowledge drops the global enable; it wins over a set strobe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gieQ <= 1'b0;
    end else if (strobes.clrSel) begin
      gieQ <= 1'b0;
    end else if (gieSet) begin
      gieQ <= 1'b1;
    end
  end

  assign reqQ = (stateQ == ST_REQ);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int VW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcPulse,
  input  logic [NSRC-1:0] enableMask,
  input  logic            gieSet,
  input  logic            ack,
  output logic            irqReq,
  output logic [VW-1:0]   irqVec,
  output logic [NSRC-1:0] pending,
  output logic            gieOut
);
  irqStrobe_t strobes;
  logic       anyCand;

  irq_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .anyCand (anyCand),
    .gieSet  (gieSet),
    .ack     (ack),
    .strobes (strobes),
    .reqQ    (irqReq),
    .gieQ    (gieOut)
  );

  irq_datapath #(.NSRC(NSRC), .VW(VW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .srcPulse   (srcPulse),
    .enableMask (enableMask),
    .strobes    (strobes),
    .anyCand    (anyCand),
    .vecQ       (irqVec),
    .pendQ      (pending)
  );
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk
  import irq_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int VW   = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rstN,
  input logic [NSRC-1:0] srcPulse,
  input logic [NSRC-1:0] enableMask,
  input logic            gieSet,
  input logic            ack,
  input logic            irqReq,
  input logic [VW-1:0]   irqVec,
  input logic [NSRC-1:0] pending,
  input logic            gieOut
);
  logic [NSRC-1:0] vecSel;
  logic [NSRC-1:0] lastSel;
  logic [NSRC-1:0] lastPulse;

  always_comb begin
    for (int i = 0; i < NSRC; i++) vecSel[i] = (irqVec == VW'(i));
  end

  always_ff @(posedge clk) begin
    lastSel   <= vecSel;
    lastPulse <= srcPulse;
  end

  p_pulse_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    (srcPulse != '0) |=> ((pending & lastPulse) == lastPulse));

  p_req_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past((pending & enableMask) != '0));

  p_vec_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !ack) |=> (irqReq && $stable(irqVec)));

  p_ack_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && ack) |=> (!irqReq && !gieOut));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && ack && ((srcPulse & vecSel) == '0)) |=> ((pending & lastSel) == '0));

  p_req_needs_gie_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(gieOut));

  p_idle_ack_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!irqReq && ack && !gieSet) |=> (gieOut == $past(gieOut)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NSRC(NSRC), .VW(VW)) u_chk (.*);

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 10;
  localparam int VW = 4;
  localparam int NVEC = 12;
  localparam int WATCHDOG = 5000;

  // {pattern, mask, expReq, expVec}
  typedef struct packed {
    logic [9:0] pat;
    logic [9:0] mask;
    logic       expReq;
    logic [3:0] expVec;
  } vecEntry_t;

  localparam vecEntry_t TABLE [NVEC] = '{
    '{10'h001, 10'h3FF, 1'b1, 4'd0},
    '{10'h200, 10'h3FF, 1'b1, 4'd9},
    '{10'h3FF, 10'h3FF, 1'b1, 4'd0},
    '{10'h3FE, 10'h3FF, 1'b1, 4'd1},
    '{10'h0F0, 10'h3FF, 1'b1, 4'd4},
    '{10'h0F0, 10'h3E0, 1'b1, 4'd5},
    '{10'h300, 10'h200, 1'b1, 4'd9},
    '{10'h0FF, 10'h300, 1'b0, 4'd0},
    '{10'h0C0, 10'h3FF, 1'b1, 4'd6},
    '{10'h180, 10'h3FF, 1'b1, 4'd7},
    '{10'h000, 10'h3FF, 1'b0, 4'd0},
    '{10'h108, 10'h3F7, 1'b1, 4'd8}
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NSRC-1:0] srcPulse = '0;
  logic [NSRC-1:0] enableMask = '0;
  logic            gieSet = 1'b0;
  logic            ack = 1'b0;
  logic            irqReq;
  logic [VW-1:0]   irqVec;
  logic [NSRC-1:0] pending;
  logic            gieOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl dut (
    .clk(clk), .rstN(rstN), .srcPulse(srcPulse), .enableMask(enableMask),
    .gieSet(gieSet), .ack(ack), .irqReq(irqReq), .irqVec(irqVec),
    .pending(pending), .gieOut(gieOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; srcPulse = '0; gieSet = 1'b0; ack = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    @(negedge clk);
    check("R1 irqReq", 32'(irqReq), 32'd0);
    check("R1 irqVec", 32'(irqVec), 32'd0);
    check("R1 pending", 32'(pending), 32'd0);
    check("R1 gieOut", 32'(gieOut), 32'd0);
    rstN = 1'b1;

    // Table: R2, R3, R4, R5, R7
    for (int k = 0; k < NVEC; k++) begin
      doReset();
      enableMask = TABLE[k].mask;
      srcPulse   = TABLE[k].pat;
      gieSet     = 1'b1;
      @(negedge clk);
      srcPulse = '0; gieSet = 1'b0;
      @(negedge clk);
      check("R2 pending", 32'(pending), 32'(TABLE[k].pat));
      check("R3/R5 irqReq", 32'(irqReq), 32'(TABLE[k].expReq));
      if (TABLE[k].expReq) begin
        check("R4 irqVec", 32'(irqVec), 32'(TABLE[k].expVec));
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        check("R7 pending", 32'(pending),
              32'(TABLE[k].pat & ~(10'h001 << TABLE[k].expVec)));
        check("R7 irqReq", 32'(irqReq), 32'd0);
        check("R7 gieOut", 32'(gieOut), 32'd0);
      end
    end

    // R8: no request without global enable
    doReset();
    enableMask = 10'h3FF;
    srcPulse = 10'h004;
    @(negedge clk);
    srcPulse = '0;
    @(negedge clk);
    @(negedge clk);
    check("R8 no req without gie", 32'(irqReq), 32'd0);
    check("R2 held", 32'(pending), 32'h004);
    gieSet = 1'b1;
    @(negedge clk);
    gieSet = 1'b0;
    check("R8 gie set", 32'(gieOut), 32'd1);
    check("R3 one edge later", 32'(irqReq), 32'd0);
    @(negedge clk);
    check("R3 irqReq", 32'(irqReq), 32'd1);
    check("R4 irqVec", 32'(irqVec), 32'd2);

    // R6, R11: higher priority arrives during a request
    srcPulse = 10'h001;
    @(negedge clk);
    srcPulse = '0;
    check("R6 vec stable", 32'(irqVec), 32'd2);
    check("R11 pulse held", 32'(pending), 32'h005);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R7 only serviced cleared", 32'(pending), 32'h001);
    gieSet = 1'b1;
    @(negedge clk);
    gieSet = 1'b0;
    @(negedge clk);
    check("R11 served later", 32'(irqReq), 32'd1);
    check("R11 vec", 32'(irqVec), 32'd0);

    // R10: pulse in the same cycle as its own acknowledge
    doReset();
    enableMask = 10'h3FF;
    srcPulse = 10'h008; gieSet = 1'b1;
    @(negedge clk);
    srcPulse = '0; gieSet = 1'b0;
    @(negedge clk);
    check("R4 irqVec", 32'(irqVec), 32'd3);
    ack = 1'b1; srcPulse = 10'h008;
    @(negedge clk);
    ack = 1'b0; srcPulse = '0;
    check("R10 pending kept", 32'(pending), 32'h008);
    check("R7 irqReq", 32'(irqReq), 32'd0);

    // R8: acknowledge beats gieSet
    gieSet = 1'b1;
    @(negedge clk);
    gieSet = 1'b0;
    @(negedge clk);
    check("R3 irqReq", 32'(irqReq), 32'd1);
    ack = 1'b1; gieSet = 1'b1;
    @(negedge clk);
    ack = 1'b0; gieSet = 1'b0;
    check("R8 ack wins", 32'(gieOut), 32'd0);

    // R9 and R5: idle acknowledge ignored, masked source served when unmasked
    enableMask = 10'h000;
    srcPulse = 10'h010; gieSet = 1'b1;
    @(negedge clk);
    srcPulse = '0; gieSet = 1'b0;
    @(negedge clk);
    check("R5 masked no req", 32'(irqReq), 32'd0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    check("R9 gie unchanged", 32'(gieOut), 32'd1);
    check("R9 pending unchanged", 32'(pending), 32'h010);
    enableMask = 10'h3FF;
    @(negedge clk);
    check("R5 unmasked req", 32'(irqReq), 32'd1);
    check("R5 unmasked vec", 32'(irqVec), 32'd4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule